// File: doc/BRIEF.md
# Multithreaded Context Scheduler

This block tracks the hardware thread contexts of one packet-processing engine and decides, on every clock, which context owns the execution pipeline. Each context is in one of three states: running, ready or sleeping. When the running context issues a memory request, it gives up the pipeline and sleeps. A later completion event for that context makes it ready again. Meanwhile a rotating-priority arbiter hands the pipeline to another ready context, so memory latency is hidden behind useful work.

Yield and wake events are single-cycle strobes that carry a thread id. They have no back-pressure: the scheduler takes one yield and one wake on every cycle. The active thread id, its valid flag, the state of every context and a count of idle cycles come out as plain status pins. Thread state codes on `thr_state` are 2'b00 ready, 2'b01 running and 2'b10 sleeping. Context t occupies bits [2t+1:2t].

Top module: `ctx_sched`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, every context reads ready (2'b00), `run_valid` is low and `idle_cycles` is 0. The search pointer starts at thread 0, so the first edge after reset grants thread 0.
- R2: At most one context is in the running state. `run_valid` is high exactly when one context is running, and `run_tid` then gives its id.
- R3: A yield whose id equals the running thread puts that thread to sleeping (2'b10) at the next edge. On that same edge, a context that was ready before the edge is granted, if one exists.
- R4: A yield whose id is not the running thread, or a yield while no thread runs, has no effect on any state.
- R5: A wake for a sleeping context makes it ready at the next edge. A wake for a ready context, or for a running context that is not yielding, changes nothing.
- R6: A yield and a wake for the same running thread in the same cycle leave that thread ready, not sleeping.
- R7: Grants are round-robin. The search begins at the thread after the last one granted and wraps from the highest id back to 0.
- R8: A running thread keeps the pipeline, with the same id, until it yields.
- R9: With no ready context, `run_valid` stays low, and `idle_cycles` increments on each edge at which `run_valid` was low. A context that becomes ready is granted at the next edge if the pipeline is free.
- R10: Yield and wake strobes are accepted on every cycle, including back to back, with no ready handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| yield_valid | input | 1 | Running thread issues a memory request and yields |
| yield_tid | input | TID_W | Id of the yielding thread |
| wake_valid | input | 1 | Memory completion event |
| wake_tid | input | TID_W | Id of the thread whose request completed |
| run_valid | output | 1 | A thread owns the pipeline |
| run_tid | output | TID_W | Id of the running thread |
| thr_state | output | 2*N_THREADS | Per-context state codes |
| idle_cycles | output | IDLE_W | Count of edges with no running thread |

## Verification
A yield chain walks the grant through every thread id and wraps past the top. This separates a correct rotating pointer from a fixed-priority one, and from a pointer that restarts at the last grant. The chain mixes in yields with the wrong id, yields while nothing runs, and a wake that arrives together with its own yield. These show whether each strobe is qualified by the current state. A stretch with every context asleep, followed by one wake, checks the idle count and how quickly the scheduler recovers. A second reset, followed by wakes aimed at ready and running contexts, shows that such wakes are ignored.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
  typedef enum logic [1:0] {
    CTX_READY = 2'b00,
    CTX_RUN   = 2'b01,
    CTX_SLEEP = 2'b10
  } ctx_state_e;
endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
  import ctx_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       yield_me,
  input  logic       wake_me,
  input  logic       grant_me,
  output logic [1:0] state
);
  ctx_state_e cur, nxt;

  always_comb begin
    nxt = cur;
    unique case (cur)
      CTX_RUN:   if (yield_me) nxt = wake_me ? CTX_READY : CTX_SLEEP;
      CTX_READY: if (grant_me) nxt = CTX_RUN;
      CTX_SLEEP: if (wake_me)  nxt = CTX_READY;
      default:   nxt = CTX_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= CTX_READY;
    else        cur <= nxt;
  end

  assign state = cur;
endmodule

// File: rtl/ctx_rr_arb.sv
module ctx_rr_arb #(
  parameter int N     = 8,
  parameter int TID_W = 3
) (
  input  logic [N-1:0]     req,
  input  logic [TID_W-1:0] start,
  output logic             found,
  output logic [TID_W-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = int'(start) + k;
      if (idx >= N) idx = idx - N;
      if (req[idx]) begin
        found = 1'b1;
        pick  = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/ctx_idle_ctr.sv
module ctx_idle_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         idle,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (idle) count <= count + 1'b1;
  end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
  import ctx_sched_pkg::*;
#(
  parameter int N_THREADS = 8,
  parameter int IDLE_W    = 16,
  localparam int TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   yield_valid,
  input  logic [TID_W-1:0]       yield_tid,
  input  logic                   wake_valid,
  input  logic [TID_W-1:0]       wake_tid,
  output logic                   run_valid,
  output logic [TID_W-1:0]       run_tid,
  output logic [2*N_THREADS-1:0] thr_state,
  output logic [IDLE_W-1:0]      idle_cycles
);
  localparam int LAST = N_THREADS - 1;

  logic [1:0]           st [N_THREADS];
  logic [N_THREADS-1:0] is_run, is_rdy, y_me, w_me, g_me;
  logic                 yield_hit, need_pick, found;
  logic [TID_W-1:0]     pick, ptr;

  genvar g;
  generate
    for (g = 0; g < N_THREADS; g++) begin : g_ctx
      assign y_me[g]   = yield_valid && (yield_tid == TID_W'(g)) && is_run[g];
      assign w_me[g]   = wake_valid && (wake_tid == TID_W'(g));
      assign g_me[g]   = need_pick && found && (pick == TID_W'(g));
      assign is_run[g] = (st[g] == CTX_RUN);
      assign is_rdy[g] = (st[g] == CTX_READY);
      assign thr_state[2*g +: 2] = st[g];

      ctx_slot u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .yield_me(y_me[g]),
        .wake_me (w_me[g]),
        .grant_me(g_me[g]),
        .state   (st[g])
      );
    end
  endgenerate

  assign run_valid = |is_run;
  assign yield_hit = |y_me;
  assign need_pick = !run_valid || yield_hit;

  always_comb begin
    run_tid = '0;
    for (int i = 0; i < N_THREADS; i++)
      if (is_run[i]) run_tid = TID_W'(i);
  end

  ctx_rr_arb #(.N(N_THREADS), .TID_W(TID_W)) u_arb (
    .req  (is_rdy),
    .start(ptr),
    .found(found),
    .pick (pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (need_pick && found)
      ptr <= (pick == TID_W'(LAST)) ? '0 : pick + 1'b1;
  end

  ctx_idle_ctr #(.W(IDLE_W)) u_idle (
    .clk  (clk),
    .rst_n(rst_n),
    .idle (!run_valid),
    .count(idle_cycles)
  );
endmodule

// File: rtl/ctx_sched_chk.sv
module ctx_sched_chk #(
  parameter int N_THREADS = 8,
  parameter int TID_W     = 3,
  parameter int IDLE_W    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   yield_valid,
  input logic [TID_W-1:0]       yield_tid,
  input logic                   wake_valid,
  input logic [TID_W-1:0]       wake_tid,
  input logic                   run_valid,
  input logic [TID_W-1:0]       run_tid,
  input logic [2*N_THREADS-1:0] thr_state,
  input logic [IDLE_W-1:0]      idle_cycles
);
  logic [1:0]           st_c [N_THREADS];
  logic [N_THREADS-1:0] run_bits, rdy_bits;
  logic [TID_W-1:0]     last_y, last_w;
  logic                 own_yield, same_wake;

  always_comb begin
    for (int i = 0; i < N_THREADS; i++) begin
      st_c[i]     = thr_state[2*i +: 2];
      run_bits[i] = (st_c[i] == 2'b01);
      rdy_bits[i] = (st_c[i] == 2'b00);
    end
  end

  assign own_yield = yield_valid && run_valid && (yield_tid == run_tid);
  assign same_wake = wake_valid && (wake_tid == yield_tid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_y <= '0;
      last_w <= '0;
    end else begin
      last_y <= yield_tid;
      last_w <= wake_tid;
    end
  end

  AST_ONE_RUNNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_bits)); // R2
  AST_VALID_TID: assert property (@(posedge clk) disable iff (!rst_n)
    run_valid |-> st_c[run_tid] == 2'b01); // R2
  AST_YIELD_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (own_yield && !same_wake) |=> st_c[last_y] == 2'b10); // R3
  AST_WAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (own_yield && same_wake) |=> st_c[last_y] == 2'b00); // R6
  AST_WAKE_READIES: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && st_c[wake_tid] == 2'b10) |=> st_c[last_w] == 2'b00); // R5
  AST_HOLD_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_valid && !(yield_valid && yield_tid == run_tid)) |=> (run_valid && $stable(run_tid))); // R8
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_valid |=> idle_cycles == IDLE_W'($past(idle_cycles) + 1'b1)); // R9
  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_valid && |rdy_bits) |=> run_valid); // R9
endmodule

bind ctx_sched ctx_sched_chk #(
  .N_THREADS(N_THREADS), .TID_W(TID_W), .IDLE_W(IDLE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .yield_valid(yield_valid), .yield_tid(yield_tid),
  .wake_valid(wake_valid), .wake_tid(wake_tid), .run_valid(run_valid),
  .run_tid(run_tid), .thr_state(thr_state), .idle_cycles(idle_cycles)
);

// File: tb/tb_ctx_sched.sv
module tb_ctx_sched;
  localparam int N = 8;
  localparam int TW = 3;
  localparam int IW = 16;
  localparam logic [1:0] RDY = 2'b00, RUN = 2'b01, SLP = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic yield_valid = 1'b0, wake_valid = 1'b0;
  logic [TW-1:0] yield_tid = '0, wake_tid = '0;
  logic run_valid;
  logic [TW-1:0] run_tid;
  logic [2*N-1:0] thr_state;
  logic [IW-1:0] idle_cycles;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ctx_sched #(.N_THREADS(N), .IDLE_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .yield_valid(yield_valid), .yield_tid(yield_tid),
    .wake_valid(wake_valid), .wake_tid(wake_tid), .run_valid(run_valid),
    .run_tid(run_tid), .thr_state(thr_state), .idle_cycles(idle_cycles)
  );

  // entry: {yv, yt, wv, wt, exp_valid, exp_tid, chk_tid, chk_state}
  localparam logic [16:0] TBL [14] = '{
    {1'b1,3'd0, 1'b0,3'd0, 1'b1,3'd1, 3'd0, SLP}, // R3
    {1'b1,3'd1, 1'b0,3'd0, 1'b1,3'd2, 3'd1, SLP}, // R3 R7
    {1'b0,3'd0, 1'b1,3'd0, 1'b1,3'd2, 3'd0, RDY}, // R5 R8
    {1'b1,3'd5, 1'b0,3'd0, 1'b1,3'd2, 3'd5, RDY}, // R4
    {1'b1,3'd2, 1'b0,3'd0, 1'b1,3'd3, 3'd2, SLP}, // R7
    {1'b1,3'd3, 1'b1,3'd3, 1'b1,3'd4, 3'd3, RDY}, // R6
    {1'b1,3'd4, 1'b0,3'd0, 1'b1,3'd5, 3'd4, SLP}, // R10
    {1'b1,3'd5, 1'b0,3'd0, 1'b1,3'd6, 3'd5, SLP},
    {1'b1,3'd6, 1'b0,3'd0, 1'b1,3'd7, 3'd6, SLP},
    {1'b1,3'd7, 1'b0,3'd0, 1'b1,3'd0, 3'd7, SLP}, // R7 wrap
    {1'b1,3'd0, 1'b0,3'd0, 1'b1,3'd3, 3'd0, SLP}, // R7
    {1'b1,3'd3, 1'b0,3'd0, 1'b0,3'd0, 3'd3, SLP}, // R9
    {1'b1,3'd3, 1'b1,3'd6, 1'b0,3'd0, 3'd3, SLP}, // R4 R9
    {1'b0,3'd0, 1'b0,3'd0, 1'b1,3'd6, 3'd6, RUN}  // R9
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  function automatic int st_of(input int t);
    return int'(thr_state[2*t +: 2]);
  endfunction

  initial begin : watchdog
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int exp_idle;
    logic model_valid;
    repeat (3) cyc();
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 valid", int'(run_valid), 0);
    chk("R1 idle", int'(idle_cycles), 0);
    chk("R1 states", int'(thr_state), 0);
    cyc();
    exp_idle = 1;
    model_valid = 1'b1;
    chk("R1 first grant valid", int'(run_valid), 1);
    chk("R1 first grant tid", int'(run_tid), 0);

    for (int v = 0; v < 14; v++) begin
      logic [16:0] e;
      e = TBL[v];
      yield_valid = e[16]; yield_tid = e[15:13];
      wake_valid  = e[12]; wake_tid  = e[11:9];
      if (!model_valid) exp_idle++;
      cyc();
      yield_valid = 1'b0; wake_valid = 1'b0;
      model_valid = e[8];
      chk("R2 R7 valid", int'(run_valid), int'(e[8]));
      if (e[8]) chk("R2 R7 tid", int'(run_tid), int'(e[7:5]));
      chk("R3 R4 R5 R6 state", st_of(int'(e[4:2])), int'(e[1:0]));
    end
    chk("R9 idle count", int'(idle_cycles), exp_idle);
    chk("R3 sleeper T0", st_of(0), int'(SLP));

    // second reset
    rst_n = 1'b0;
    repeat (2) cyc();
    rst_n = 1'b1;
    chk("R1 re-reset valid", int'(run_valid), 0);
    chk("R1 re-reset idle", int'(idle_cycles), 0);
    chk("R1 re-reset states", int'(thr_state), 0);
    cyc();
    chk("R1 re-reset grant", int'(run_tid), 0);
    // R5 wake to ready context ignored
    wake_valid = 1'b1; wake_tid = 3'd1;
    cyc();
    wake_valid = 1'b0;
    chk("R5 ready stays", st_of(1), int'(RDY));
    // R5 wake to running context ignored
    wake_valid = 1'b1; wake_tid = 3'd0;
    cyc();
    wake_valid = 1'b0;
    chk("R5 running stays", st_of(0), int'(RUN));
    chk("R8 tid held", int'(run_tid), 0);
    // R8 hold over quiet cycles
    repeat (3) cyc();
    chk("R8 still valid", int'(run_valid), 1);
    chk("R8 still tid", int'(run_tid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule